// File: doc/BRIEF.md
# Directory-Tracked Coherence Home Controller

This block is the single point of ordering for coherent accesses from four requesting agents to a shared pool of cache lines. It accepts one request at a time: a read that may be shared, a read for exclusive ownership, or an eviction. A per-line directory records which agents hold a copy and whether one of them holds it modified. The controller uses that record to decide which agents must be snooped, collects their answers, and fills in the line either from a modified peer copy or from a backing memory port. It then returns a single completion that carries the granted state and the line data.

Snoops go only to agents that the directory lists as holders, and never to the requester. A modified peer copy is forwarded straight to the requester instead of being read from memory. On a shared read that modified copy is also written back, so every holder ends up clean. An exclusive read invalidates every other holder before ownership is granted. The directory entry is rewritten in the same cycle that the completion is accepted.

Top module: `coh_home`

## Requirements
- R1: After reset `req_ready` is 1, `snp_valid`, `mem_req_valid` and `cmp_valid` are 0, and every directory entry is empty, so the first read of any line sends no snoop and reads memory.
- R2: A shared read (`req_op`=0) snoops only the agent recorded as modified owner, if that agent is not the requester, with `snp_invalidate`=0. Other sharers are not snooped and remain in the directory. The completion grant is shared (`cmp_state`=1).
- R3: A unique read (`req_op`=1) sends one invalidating snoop (`snp_invalidate`=1) to every recorded holder except the requester. The completion grant is unique (`cmp_state`=2), and afterwards the requester is the only holder and is marked modified.
- R4: When a snooped agent answers with `sresp_dirty`=1, its `sresp_data` is returned as `cmp_data` and no memory read is issued.
- R5: On a shared read served by a modified peer, the forwarded data is written to memory (`mem_req_we`=1) before the completion, and the line is recorded as clean.
- R6: When no modified peer supplies the line, one memory read is issued and `cmp_data` equals `mem_rsp_rdata`. The completion is not raised before the memory response arrives.
- R7: An eviction (`req_op`=2) sends no snoops, completes with `cmp_state`=0 and removes the requester from the directory. If the requester was the modified owner, `req_data` is written to memory.
- R8: `req_ready` is 0 from the cycle after a request is accepted until the completion handshake. Only one transaction is in progress at a time.
- R9: Each transaction issues at most one snoop pulse and never targets the requester. The completion waits for a response from every snooped agent.
- R10: Directory updates made at each completion decide which snoops the following requests to that line issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_agent | input | AW | Requesting agent index |
| req_op | input | 2 | 0 shared read, 1 unique read, 2 evict |
| req_line | input | LW | Line index |
| req_data | input | DW | Line data supplied with an evict |
| snp_valid | output | 1 | One-cycle snoop pulse |
| snp_targets | output | NA | Agents being snooped |
| snp_invalidate | output | 1 | 1 invalidate, 0 downgrade to shared |
| snp_line | output | LW | Snooped line |
| sresp_valid | input | 1 | Snoop response |
| sresp_agent | input | AW | Responding agent |
| sresp_dirty | input | 1 | Response carries modified data |
| sresp_data | input | DW | Forwarded data |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_line | output | LW | Memory line index |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | DW | Read data |
| cmp_valid | output | 1 | Completion present |
| cmp_ready | input | 1 | Requester takes completion |
| cmp_agent | output | AW | Agent the completion is for |
| cmp_state | output | 2 | 0 none, 1 shared, 2 unique |
| cmp_data | output | DW | Line data |

## Verification
Assertions check several rules on every cycle. While a snoop, memory access or completion is outstanding, the request side stays closed. A snoop is a single pulse, never aimed at the requester, and a downgrade hits exactly one owner. A completion never appears with snoop answers still owed. Memory and completion outputs hold steady under back-pressure. Only the bench's scenarios show that the right data is forwarded or written back, and that the snoop sets follow from the history of earlier transactions to the same line. The bench confirms both against its own model of the directory and memory, over directed sequences and a random mix aimed at a few contended lines.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {OP_SHARED = 2'd0, OP_UNIQUE = 2'd1, OP_EVICT = 2'd2} op_e;
  typedef enum logic [1:0] {GR_NONE = 2'd0, GR_SHARED = 2'd1, GR_UNIQUE = 2'd2} grant_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_SNP, ST_WAIT, ST_MRD, ST_MRSP, ST_MWR, ST_CMP
  } hstate_e;
endpackage

// File: rtl/coh_dir.sv
module coh_dir #(
  parameter int NA    = 4,
  parameter int LINES = 16,
  localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [LW-1:0] rd_line,
  output logic [NA-1:0] rd_mask,
  output logic          rd_dirty,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_line,
  input  logic [NA-1:0] wr_mask,
  input  logic          wr_dirty
);
  logic [NA:0]      store [LINES];
  logic [NA:0]      rd_q;
  logic [LINES-1:0] vld;
  logic             rd_vld_q;

  // RAM-style body without reset; a flop per line marks written entries
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_line] <= {wr_dirty, wr_mask};
    if (rd_en) rd_q <= store[rd_line];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      if (wr_en) vld[wr_line] <= 1'b1;
      if (rd_en) rd_vld_q <= vld[rd_line];
    end
  end

  assign rd_mask  = rd_vld_q ? rd_q[NA-1:0] : '0;
  assign rd_dirty = rd_vld_q & rd_q[NA];

  AST_DIRTY_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_dirty |-> $countones(wr_mask) == 1); // R10
endmodule

// File: rtl/coh_snoop_collect.sv
module coh_snoop_collect #(
  parameter int NA = 4,
  parameter int DW = 32,
  localparam int AW = (NA > 1) ? $clog2(NA) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [NA-1:0] load_mask,
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_agent,
  input  logic          rsp_dirty,
  input  logic [DW-1:0] rsp_data,
  output logic [NA-1:0] pending,
  output logic          got_dirty,
  output logic [DW-1:0] fwd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= '0;
      got_dirty <= 1'b0;
      fwd_data  <= '0;
    end else if (load) begin
      pending   <= load_mask;
      got_dirty <= 1'b0;
    end else if (rsp_valid) begin
      pending[rsp_agent] <= 1'b0;
      if (rsp_dirty) begin
        got_dirty <= 1'b1;
        fwd_data  <= rsp_data;
      end
    end
  end

  AST_RSP_FROM_SNOOPED: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !load |-> pending[rsp_agent]); // R9
endmodule

// File: rtl/coh_home.sv
module coh_home
  import coh_pkg::*;
#(
  parameter int NA    = 4,
  parameter int LINES = 16,
  parameter int DW    = 32,
  localparam int AW   = (NA > 1) ? $clog2(NA) : 1,
  localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_agent,
  input  logic [1:0]    req_op,
  input  logic [LW-1:0] req_line,
  input  logic [DW-1:0] req_data,
  output logic          snp_valid,
  output logic [NA-1:0] snp_targets,
  output logic          snp_invalidate,
  output logic [LW-1:0] snp_line,
  input  logic          sresp_valid,
  input  logic [AW-1:0] sresp_agent,
  input  logic          sresp_dirty,
  input  logic [DW-1:0] sresp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [LW-1:0] mem_req_line,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata,
  output logic          cmp_valid,
  input  logic          cmp_ready,
  output logic [AW-1:0] cmp_agent,
  output logic [1:0]    cmp_state,
  output logic [DW-1:0] cmp_data
);
  localparam logic [NA-1:0] ONE = {{(NA-1){1'b0}}, 1'b1};

  hstate_e       st;
  op_e           cur_op;
  logic [AW-1:0] cur_agent;
  logic [LW-1:0] cur_line;
  logic [DW-1:0] cur_wdata, line_data;
  logic [NA-1:0] ent_mask, snp_tgt, self_bit, others, look_tgt, pending, new_mask;
  logic          ent_dirty, snp_inv_q, owner_is_req, got_dirty, new_dirty;
  logic [NA-1:0] dir_mask;
  logic          dir_dirty;
  logic [DW-1:0] fwd_data;

  coh_dir #(.NA(NA), .LINES(LINES)) u_dir (
    .clk(clk), .rst(rst),
    .rd_en(st == ST_IDLE && req_valid), .rd_line(req_line),
    .rd_mask(dir_mask), .rd_dirty(dir_dirty),
    .wr_en(st == ST_CMP && cmp_ready), .wr_line(cur_line),
    .wr_mask(new_mask), .wr_dirty(new_dirty)
  );

  coh_snoop_collect #(.NA(NA), .DW(DW)) u_col (
    .clk(clk), .rst(rst),
    .load(st == ST_SNP), .load_mask(snp_tgt),
    .rsp_valid(sresp_valid), .rsp_agent(sresp_agent),
    .rsp_dirty(sresp_dirty), .rsp_data(sresp_data),
    .pending(pending), .got_dirty(got_dirty), .fwd_data(fwd_data)
  );

  // Snoop target selection from the looked-up entry
  always_comb begin
    self_bit     = ONE << cur_agent;
    others       = dir_mask & ~self_bit;
    owner_is_req = dir_dirty && dir_mask[cur_agent];
    unique case (cur_op)
      OP_SHARED: look_tgt = (dir_dirty && !owner_is_req) ? others : '0;
      OP_UNIQUE: look_tgt = others;
      default:   look_tgt = '0;
    endcase
  end

  // Directory entry written at completion handshake
  always_comb begin
    unique case (cur_op)
      OP_SHARED: begin new_mask = ent_mask | self_bit; new_dirty = 1'b0; end
      OP_UNIQUE: begin new_mask = self_bit;            new_dirty = 1'b1; end
      default:   begin
        new_mask  = ent_mask & ~self_bit;
        new_dirty = ent_dirty && !ent_mask[cur_agent];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cur_op    <= OP_SHARED;
      cur_agent <= '0;
      cur_line  <= '0;
      cur_wdata <= '0;
      line_data <= '0;
      ent_mask  <= '0;
      ent_dirty <= 1'b0;
      snp_tgt   <= '0;
      snp_inv_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          cur_op    <= op_e'(req_op);
          cur_agent <= req_agent;
          cur_line  <= req_line;
          cur_wdata <= req_data;
          st        <= ST_LOOK;
        end
        ST_LOOK: begin
          ent_mask  <= dir_mask;
          ent_dirty <= dir_dirty;
          snp_tgt   <= look_tgt;
          snp_inv_q <= (cur_op == OP_UNIQUE);
          if (look_tgt != '0)        st <= ST_SNP;
          else if (cur_op == OP_EVICT) begin
            if (owner_is_req) begin
              line_data <= cur_wdata;
              st        <= ST_MWR;
            end else st <= ST_CMP;
          end else st <= ST_MRD;
        end
        ST_SNP:  st <= ST_WAIT;
        ST_WAIT: if (pending == '0) begin
          if (got_dirty) begin
            line_data <= fwd_data;
            st        <= (cur_op == OP_SHARED) ? ST_MWR : ST_CMP;
          end else st <= ST_MRD;
        end
        ST_MRD:  if (mem_req_ready) st <= ST_MRSP;
        ST_MRSP: if (mem_rsp_valid) begin
          line_data <= mem_rsp_rdata;
          st        <= ST_CMP;
        end
        ST_MWR:  if (mem_req_ready) st <= ST_CMP;
        ST_CMP:  if (cmp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready      = (st == ST_IDLE);
  assign snp_valid      = (st == ST_SNP);
  assign snp_targets    = snp_tgt;
  assign snp_invalidate = snp_inv_q;
  assign snp_line       = cur_line;
  assign mem_req_valid  = (st == ST_MRD) || (st == ST_MWR);
  assign mem_req_we     = (st == ST_MWR);
  assign mem_req_line   = cur_line;
  assign mem_req_wdata  = line_data;
  assign cmp_valid      = (st == ST_CMP);
  assign cmp_agent      = cur_agent;
  assign cmp_data       = line_data;
  always_comb begin
    unique case (cur_op)
      OP_SHARED: cmp_state = GR_SHARED;
      OP_UNIQUE: cmp_state = GR_UNIQUE;
      default:   cmp_state = GR_NONE;
    endcase
  end

  AST_BUSY_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid || snp_valid || mem_req_valid) |-> !req_ready); // R8
  AST_NO_SELF_SNOOP: assert property (@(posedge clk) disable iff (rst)
    snp_valid |-> !snp_targets[cmp_agent]); // R9
  AST_SNOOP_PULSE: assert property (@(posedge clk) disable iff (rst)
    snp_valid |=> !snp_valid); // R9
  AST_DOWNGRADE_ONE: assert property (@(posedge clk) disable iff (rst)
    snp_valid && !snp_invalidate |-> $countones(snp_targets) == 1); // R2
  AST_ACKS_BEFORE_CMP: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |-> pending == '0); // R9
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmp_valid && !cmp_ready |=> cmp_valid && $stable(cmp_data)); // R6
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_wdata)); // R5
endmodule

// File: tb/coh_home_bench.sv
module coh_home_bench;
  localparam int NA = 4, LINES = 8, DW = 32, AW = 2, LW = 3;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic          req_valid = 0, req_ready;
  logic [AW-1:0] req_agent = 0;
  logic [1:0]    req_op = 0;
  logic [LW-1:0] req_line = 0;
  logic [DW-1:0] req_data = 0;
  logic          snp_valid, snp_invalidate;
  logic [NA-1:0] snp_targets;
  logic [LW-1:0] snp_line;
  logic          sresp_valid = 0, sresp_dirty = 0;
  logic [AW-1:0] sresp_agent = 0;
  logic [DW-1:0] sresp_data = 0;
  logic          mem_req_valid, mem_req_we;
  logic          mem_req_ready = 1;
  logic [LW-1:0] mem_req_line;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 0;
  logic [DW-1:0] mem_rsp_rdata = 0;
  logic          cmp_valid, cmp_ready = 1;
  logic [AW-1:0] cmp_agent;
  logic [1:0]    cmp_state;
  logic [DW-1:0] cmp_data;

  coh_home #(.NA(NA), .LINES(LINES), .DW(DW)) u_coh_home (.*);

  int checks = 0, errors = 0;
  logic [NA-1:0] m_mask  [LINES];
  logic          m_dirty [LINES];
  logic [DW-1:0] m_mem   [LINES];
  logic [DW-1:0] m_own   [LINES];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NA-1:0] exp_targets(input int a, input int op, input int ln);
    logic [NA-1:0] self_b = 4'b1 << a;
    if (op == 1) return m_mask[ln] & ~self_b;
    if (op == 0 && m_dirty[ln] && !m_mask[ln][a]) return m_mask[ln];
    return '0;
  endfunction

  task automatic run_txn(input int a, input int op, input int ln);
    logic [NA-1:0] et = exp_targets(a, op, ln);
    logic [NA-1:0] pend = '0;
    bit peer_dirty = m_dirty[ln] && !m_mask[ln][a];
    bit own_dirty  = m_dirty[ln] && m_mask[ln][a];
    int exp_rd = (op != 2 && !peer_dirty) ? 1 : 0;
    int exp_wr = ((op == 0 && peer_dirty) || (op == 2 && own_dirty)) ? 1 : 0;
    logic [DW-1:0] wd = own_dirty ? m_own[ln] : $urandom;
    logic [DW-1:0] exp_data = peer_dirty ? m_own[ln] : m_mem[ln];
    logic [DW-1:0] exp_wdata = (op == 2) ? wd : m_own[ln];
    int snp_cnt = 0, rd = 0, wr = 0, dly = 0;
    bit done = 0;
    @(negedge clk);
    req_valid = 1; req_agent = AW'(a); req_op = 2'(op); req_line = LW'(ln); req_data = wd;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R8 ready low while busy", DW'(req_ready), 0);
    for (int cyc = 0; cyc < 100 && !done; cyc++) begin
      sresp_valid = 0; sresp_dirty = 0; mem_rsp_valid = 0;
      if (dly > 0) begin
        dly--;
        if (dly == 0) begin mem_rsp_valid = 1; mem_rsp_rdata = m_mem[ln]; end
      end
      if (snp_valid) begin
        snp_cnt++;
        chk(snp_targets == et, "R2/R3/R10 snoop targets", DW'(snp_targets), DW'(et));
        chk(snp_invalidate == (op == 1), "R2/R3 snoop kind", DW'(snp_invalidate), DW'(op == 1));
        chk(!snp_targets[a], "R9 no self snoop", DW'(snp_targets), DW'(et));
        pend = snp_targets;
      end else if (pend != '0) begin
        for (int k = 0; k < NA; k++) if (pend[k] && !sresp_valid) begin
          sresp_valid = 1; sresp_agent = AW'(k);
          sresp_dirty = m_dirty[ln]; sresp_data = m_own[ln];
          pend[k] = 0;
        end
      end
      if (mem_req_valid) begin
        if (mem_req_we) begin
          wr++;
          chk(mem_req_wdata == exp_wdata, "R5/R7 writeback data", mem_req_wdata, exp_wdata);
        end else begin
          rd++; dly = 2;
        end
      end
      if (cmp_valid) begin
        done = 1;
        chk(pend == '0, "R9 all snoops answered", DW'(pend), 0);
        chk(cmp_state == ((op == 2) ? 2'd0 : (op == 1) ? 2'd2 : 2'd1), "R2/R3/R7 grant",
            DW'(cmp_state), DW'((op == 2) ? 0 : (op == 1) ? 2 : 1));
        if (op != 2)
          chk(cmp_data == exp_data, peer_dirty ? "R4 forwarded data" : "R6 memory data", cmp_data, exp_data);
      end
      @(negedge clk);
    end
    sresp_valid = 0; mem_rsp_valid = 0;
    chk(done, "R9 completion arrived", DW'(done), 1);
    chk(snp_cnt == ((et != '0) ? 1 : 0), "R9 snoop count", DW'(snp_cnt), DW'((et != '0) ? 1 : 0));
    chk(rd == exp_rd, "R4/R6 memory reads", DW'(rd), DW'(exp_rd));
    chk(wr == exp_wr, "R5/R7 memory writes", DW'(wr), DW'(exp_wr));
    // model update
    if (exp_wr == 1) m_mem[ln] = exp_wdata;
    case (op)
      0: begin m_mask[ln] |= (4'b1 << a); m_dirty[ln] = 0; end
      1: begin m_mask[ln] = 4'b1 << a; m_dirty[ln] = 1; m_own[ln] = $urandom; end
      default: begin
        if (own_dirty) m_dirty[ln] = 0;
        m_mask[ln] &= ~(4'b1 << a);
      end
    endcase
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < LINES; i++) begin
      m_mask[i] = '0; m_dirty[i] = 0; m_own[i] = '0; m_mem[i] = 32'hC0DE_0000 + i;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready after reset", DW'(req_ready), 1);
    chk(!snp_valid && !mem_req_valid && !cmp_valid, "R1 outputs idle", DW'({snp_valid, mem_req_valid, cmp_valid}), 0);
    // directed sequence on line 5
    run_txn(0, 0, 5);  // R1 empty entry: memory read, no snoop
    run_txn(1, 0, 5);  // R2 sharers left alone
    run_txn(2, 1, 5);  // R3 invalidate agents 0 and 1
    run_txn(3, 0, 5);  // R4 R5 forward from owner 2, writeback
    run_txn(1, 1, 5);  // R3 invalidate 2,3 clean, memory read
    run_txn(1, 2, 5);  // R7 dirty evict writeback
    run_txn(0, 2, 5);  // R7 evict by non-holder
    run_txn(2, 0, 5);  // R10 entry now empty
    run_txn(2, 1, 5);  // sole sharer upgrade: no snoop
    run_txn(0, 1, 5);  // R4 unique forward, no writeback
    // random mix on contended lines
    for (int n = 0; n < 400; n++) begin
      int a = $urandom % NA, ln = $urandom % 4, op = $urandom % 3;
      if (m_dirty[ln] && m_mask[ln][a]) op = 2;
      run_txn(a, op, ln);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule